// File: doc/BRIEF.md
# Instruction Exception Classifier

This block sits in the decode stage of a simple in-order 32-bit processor. For every issued instruction it takes a set of class flags that an earlier decoder has produced, the state of the floating-point unit's standby control and the two divide operands. From these it decides whether the instruction must raise an exception, and which kind. The result is registered and appears one cycle after issue as a single-cycle strobe with a category code. For trap instructions the trap's vector number comes out with it.

The block also remembers across cycles whether the next instruction sits in the delay slot of a branch. An instruction that would be legal elsewhere may be refused in that position. Undefined code is split into two categories, one inside a slot and one outside it. A flush input drops any pending slot and cancels the instruction issued in the same cycle. Opcode decoding, vector fetch, stacking and floating-point arithmetic faults are handled elsewhere.

Top module: `insn_exc_classifier`

## Requirements
- R1: A valid trap instruction outside a delay slot produces category 1 (trap), and `exc_vec` carries the `trap_vec` value that was issued with it. In every other cycle `exc_vec` is 0.
- R2: After a valid delayed branch that raised no exception and was not flushed, the next valid instruction is in a delay slot. Idle cycles (`issue_vld` low) in between do not end the slot.
- R3: In a delay slot, category 2 (slot illegal) is raised by any of these: undefined code, a PC-writing instruction, a trap, a delayed branch, a 32-bit-long instruction, the register-bank restore, or either divide. This category takes priority over the divide checks.
- R4: Undefined code outside a delay slot produces category 3 (general illegal). This takes priority over trap and divide checks.
- R5: When `fpu_standby` is high, an instruction flagged FPU-related counts as undefined code (category 2 or 3 depending on position). When `fpu_standby` is low, that flag alone raises nothing.
- R6: A signed or an unsigned divide whose divisor is 0 produces category 4 (division by zero).
- R7: A signed divide with dividend 32'h8000_0000 and divisor 32'hFFFF_FFFF produces category 5 (division overflow). An unsigned divide with the same operands raises nothing.
- R8: A slot never chains. Any valid instruction issued in a slot ends it. A delayed branch in a slot raises category 2 and leaves no new slot, so the next instruction is judged as outside a slot.
- R9: A high `flush` clears any pending slot and cancels the instruction issued in the same cycle: that instruction produces no strobe and opens no slot.
- R10: Outputs are registered. `exc_strobe` goes high exactly one cycle after an offending valid instruction and stays high for one cycle. When the strobe is low, `exc_cat` is 0.
- R11: Reset is synchronous and active high. It drives `exc_strobe`, `exc_cat` and `exc_vec` to 0 and leaves no slot pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| flush | input | 1 | Pipeline flush; clears the slot and cancels the current issue |
| cls_trap | input | 1 | Instruction is a trap |
| cls_dbranch | input | 1 | Instruction is a delayed branch |
| cls_pcwrite | input | 1 | Instruction writes the program counter |
| cls_long | input | 1 | Instruction is 32 bits long |
| cls_bankrest | input | 1 | Instruction is the register-bank restore |
| cls_sdiv | input | 1 | Instruction is the signed divide |
| cls_udiv | input | 1 | Instruction is the unsigned divide |
| cls_undef | input | 1 | Instruction is undefined code |
| cls_fpu | input | 1 | Instruction is FPU or FPU-related |
| fpu_standby | input | 1 | Floating-point unit is in standby |
| trap_vec | input | VEC_W | Immediate vector number of a trap |
| dividend | input | DATA_W | Divide dividend |
| divisor | input | DATA_W | Divide divisor |
| exc_strobe | output | 1 | One-cycle exception indication |
| exc_cat | output | 3 | Exception category (0 none, 1 trap, 2 slot illegal, 3 general illegal, 4 divide by zero, 5 divide overflow) |
| exc_vec | output | VEC_W | Trap vector number; 0 unless category is trap |

## Verification
Some properties are checked by assertions on every cycle: a slot ends after any issue inside it, flush clears the slot, a strobe always follows a valid issue, overflow arises only from a signed divide, a divide in a slot is always reported as slot illegal, and a trap vector is passed through unchanged. Other behaviour can only be shown by the bench's scenarios. These include the full priority order between categories, the effect of FPU standby, idle cycles that hold a slot open, a reset that drops a pending slot, and the unsigned divide that ignores the overflow operands. The bench compares every cycle against a reference model.

// File: rtl/iec_pkg.sv
package iec_pkg;

  typedef enum logic [2:0] {
    CAT_NONE     = 3'd0,
    CAT_TRAP     = 3'd1,
    CAT_SLOT_ILL = 3'd2,
    CAT_GEN_ILL  = 3'd3,
    CAT_DIV_ZERO = 3'd4,
    CAT_DIV_OVF  = 3'd5
  } exc_cat_e;

  typedef struct packed {
    logic trap;
    logic dbranch;
    logic pcwrite;
    logic long_op;
    logic bankrest;
    logic sdiv;
    logic udiv;
    logic undef;
    logic fpu;
  } insn_flags_t;

endpackage

// File: rtl/iec_div_check.sv
module iec_div_check #(
  parameter int DATA_W = 32
) (
  input  logic              is_sdiv,
  input  logic              is_udiv,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              div_zero,
  output logic              div_ovf
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MINUS_ONE = {DATA_W{1'b1}};

  logic divisor_zero;

  always_comb begin
    divisor_zero = (divisor == '0);
    div_zero     = (is_sdiv | is_udiv) & divisor_zero;
    // overflow exists only for the signed form
    div_ovf      = is_sdiv & (dividend == MOST_NEG) & (divisor == MINUS_ONE);
  end
endmodule

// File: rtl/iec_priority.sv
module iec_priority
  import iec_pkg::*;
(
  input  insn_flags_t flags,
  input  logic        in_slot,
  input  logic        fpu_standby,
  input  logic        div_zero,
  input  logic        div_ovf,
  output exc_cat_e    cat
);
  logic undef_eff;
  logic slot_bad;

  always_comb begin
    // FPU work while the unit sleeps counts as undefined code
    undef_eff = flags.undef | (flags.fpu & fpu_standby);
    slot_bad  = undef_eff | flags.pcwrite | flags.trap | flags.dbranch |
                flags.long_op | flags.bankrest | flags.sdiv | flags.udiv;
    cat = CAT_NONE;
    if (in_slot && slot_bad)  cat = CAT_SLOT_ILL;
    else if (undef_eff)       cat = CAT_GEN_ILL;
    else if (flags.trap)      cat = CAT_TRAP;
    else if (div_zero)        cat = CAT_DIV_ZERO;
    else if (div_ovf)         cat = CAT_DIV_OVF;
  end
endmodule

// File: rtl/iec_slot_tracker.sv
module iec_slot_tracker (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic issue_fire,
  input  logic is_dbranch,
  input  logic raised,
  output logic slot_q
);
  always_ff @(posedge clk) begin
    if (rst || flush)    slot_q <= 1'b0;
    else if (issue_fire) slot_q <= is_dbranch & ~raised;
  end

  AST_SLOT_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (slot_q && issue_fire) |=> !slot_q); // R8
  AST_FLUSH_DROPS_SLOT: assert property (@(posedge clk) disable iff (rst)
    flush |=> !slot_q); // R9
endmodule

// File: rtl/insn_exc_classifier.sv
module insn_exc_classifier
  import iec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_vld,
  input  logic              flush,
  input  logic              cls_trap,
  input  logic              cls_dbranch,
  input  logic              cls_pcwrite,
  input  logic              cls_long,
  input  logic              cls_bankrest,
  input  logic              cls_sdiv,
  input  logic              cls_udiv,
  input  logic              cls_undef,
  input  logic              cls_fpu,
  input  logic              fpu_standby,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              exc_strobe,
  output logic [2:0]        exc_cat,
  output logic [VEC_W-1:0]  exc_vec
);
  insn_flags_t flags;
  logic        issue_fire;
  logic        slot;
  logic        div_zero;
  logic        div_ovf;
  exc_cat_e    cat_now;
  logic        raised;

  exc_cat_e         cat_q;
  logic             strobe_q;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    flags.trap     = cls_trap;
    flags.dbranch  = cls_dbranch;
    flags.pcwrite  = cls_pcwrite;
    flags.long_op  = cls_long;
    flags.bankrest = cls_bankrest;
    flags.sdiv     = cls_sdiv;
    flags.udiv     = cls_udiv;
    flags.undef    = cls_undef;
    flags.fpu      = cls_fpu;
    issue_fire     = issue_vld & ~flush;
    raised         = issue_fire & (cat_now != CAT_NONE);
  end

  iec_div_check #(.DATA_W(DATA_W)) u_div (
    .is_sdiv  (cls_sdiv),
    .is_udiv  (cls_udiv),
    .dividend (dividend),
    .divisor  (divisor),
    .div_zero (div_zero),
    .div_ovf  (div_ovf)
  );

  iec_priority u_prio (
    .flags       (flags),
    .in_slot     (slot),
    .fpu_standby (fpu_standby),
    .div_zero    (div_zero),
    .div_ovf     (div_ovf),
    .cat         (cat_now)
  );

  iec_slot_tracker u_slot (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .issue_fire (issue_fire),
    .is_dbranch (cls_dbranch),
    .raised     (raised),
    .slot_q     (slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      cat_q    <= CAT_NONE;
      vec_q    <= '0;
    end else begin
      strobe_q <= raised;
      cat_q    <= raised ? cat_now : CAT_NONE;
      vec_q    <= (raised && cat_now == CAT_TRAP) ? trap_vec : '0;
    end
  end

  assign exc_strobe = strobe_q;
  assign exc_cat    = cat_q;
  assign exc_vec    = vec_q;

  AST_STROBE_FROM_ISSUE: assert property (@(posedge clk) disable iff (rst)
    exc_strobe |-> $past(issue_vld && !flush)); // R10
  AST_OVF_SIGNED_ONLY: assert property (@(posedge clk) disable iff (rst)
    (exc_cat == CAT_DIV_OVF) |-> $past(cls_sdiv)); // R7
  AST_SLOT_DIV_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(slot && issue_fire && (cls_sdiv || cls_udiv)) |-> (exc_cat == CAT_SLOT_ILL)); // R3
  AST_TRAP_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (exc_cat == CAT_TRAP) |-> (exc_vec == $past(trap_vec))); // R1
endmodule

// File: tb/tb_insn_exc_classifier.sv
module tb_insn_exc_classifier;
  localparam int DATA_W = 32;
  localparam int VEC_W  = 8;
  localparam logic [DATA_W-1:0] MOST_NEG = 32'h8000_0000;
  localparam logic [DATA_W-1:0] MINUS1   = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_vld = 0, flush = 0;
  logic cls_trap = 0, cls_dbranch = 0, cls_pcwrite = 0, cls_long = 0, cls_bankrest = 0;
  logic cls_sdiv = 0, cls_udiv = 0, cls_undef = 0, cls_fpu = 0, fpu_standby = 0;
  logic [VEC_W-1:0]  trap_vec = '0;
  logic [DATA_W-1:0] dividend = '0, divisor = 32'd1;
  logic              exc_strobe;
  logic [2:0]        exc_cat;
  logic [VEC_W-1:0]  exc_vec;

  int n_checks = 0, n_fail = 0;
  bit model_slot = 0;

  always #4 clk = ~clk;

  insn_exc_classifier #(.DATA_W(DATA_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .flush(flush),
    .cls_trap(cls_trap), .cls_dbranch(cls_dbranch), .cls_pcwrite(cls_pcwrite),
    .cls_long(cls_long), .cls_bankrest(cls_bankrest), .cls_sdiv(cls_sdiv),
    .cls_udiv(cls_udiv), .cls_undef(cls_undef), .cls_fpu(cls_fpu),
    .fpu_standby(fpu_standby), .trap_vec(trap_vec), .dividend(dividend),
    .divisor(divisor), .exc_strobe(exc_strobe), .exc_cat(exc_cat), .exc_vec(exc_vec)
  );

  function automatic logic [2:0] ref_cat(bit slot);
    bit und;
    und = cls_undef | (cls_fpu & fpu_standby);
    if (slot && (und | cls_pcwrite | cls_trap | cls_dbranch | cls_long |
                 cls_bankrest | cls_sdiv | cls_udiv)) return 3'd2;
    if (und) return 3'd3;
    if (cls_trap) return 3'd1;
    if ((cls_sdiv | cls_udiv) && divisor == '0) return 3'd4;
    if (cls_sdiv && dividend == MOST_NEG && divisor == MINUS1) return 3'd5;
    return 3'd0;
  endfunction

  function automatic string req_of(logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R3/R8";
      3'd3: return "R4/R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic clear_flags();
    cls_trap = 0; cls_dbranch = 0; cls_pcwrite = 0; cls_long = 0; cls_bankrest = 0;
    cls_sdiv = 0; cls_udiv = 0; cls_undef = 0; cls_fpu = 0;
  endtask

  // Inputs are already set at a falling edge; compute, clock, compare at next falling edge
  task automatic run_cycle(string tag);
    logic [2:0] ec;
    logic [VEC_W-1:0] ev;
    ec = 3'd0; ev = '0;
    if (rst) model_slot = 0;
    else begin
      if (issue_vld && !flush) begin
        ec = ref_cat(model_slot);
        if (ec == 3'd1) ev = trap_vec;
        model_slot = cls_dbranch && (ec == 3'd0);
      end
      if (flush) model_slot = 0;
    end
    @(negedge clk);
    n_checks++;
    if (exc_strobe !== (ec != 0) || exc_cat !== ec || exc_vec !== ev) begin
      n_fail++;
      $display("FAIL %s %s: got strobe=%0b cat=%0d vec=%0h, expected strobe=%0b cat=%0d vec=%0h",
               tag, (ec != 0) ? req_of(ec) : "R10", exc_strobe, exc_cat, exc_vec,
               (ec != 0), ec, ev);
    end
  endtask

  task automatic issue_dbranch();
    clear_flags(); issue_vld = 1; cls_dbranch = 1; cls_pcwrite = 1;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R11: reset dominates an offending issue
    issue_vld = 1; cls_trap = 1; trap_vec = 8'h33;
    run_cycle("R11 reset");
    run_cycle("R11 reset");
    rst = 0;
    // R1 trap
    clear_flags(); cls_trap = 1; cls_pcwrite = 1; trap_vec = 8'hA5; run_cycle("R1 trap");
    // R10 legal instruction gives nothing
    clear_flags(); run_cycle("R10 legal");
    // R2/R3 branch then divide in slot: slot illegal over divide-zero
    issue_dbranch(); run_cycle("R2 branch");
    clear_flags(); cls_udiv = 1; divisor = 0; run_cycle("R3 div in slot");
    // R2 idle gap keeps slot
    issue_dbranch(); run_cycle("R2 branch");
    clear_flags(); issue_vld = 0; run_cycle("R2 idle");
    issue_vld = 1; cls_long = 1; run_cycle("R2 long in slot after idle");
    // R8 branch in slot: slot illegal, no chaining
    issue_dbranch(); run_cycle("R8 branch");
    issue_dbranch(); run_cycle("R8 branch in slot");
    clear_flags(); cls_bankrest = 1; run_cycle("R8 after slot");
    // R4 undefined outside slot beats trap
    clear_flags(); cls_undef = 1; cls_trap = 1; run_cycle("R4 undef");
    // R5 FPU standby
    clear_flags(); cls_fpu = 1; fpu_standby = 0; run_cycle("R5 fpu awake");
    fpu_standby = 1; run_cycle("R5 fpu standby");
    issue_dbranch(); run_cycle("R5 branch");
    clear_flags(); cls_fpu = 1; run_cycle("R5 fpu in slot");
    fpu_standby = 0;
    // R6 / R7
    clear_flags(); cls_sdiv = 1; divisor = 0; run_cycle("R6 sdiv zero");
    dividend = MOST_NEG; divisor = MINUS1; run_cycle("R7 sdiv ovf");
    clear_flags(); cls_udiv = 1; run_cycle("R7 udiv same operands");
    // R9 flush
    issue_dbranch(); run_cycle("R9 branch");
    clear_flags(); issue_vld = 0; flush = 1; run_cycle("R9 flush");
    flush = 0; issue_vld = 1; cls_long = 1; run_cycle("R9 long after flush");
    clear_flags(); cls_undef = 1; flush = 1; run_cycle("R9 flush cancels");
    flush = 0; clear_flags(); run_cycle("R9 quiet");
    // R11 reset drops pending slot
    issue_dbranch(); run_cycle("R11 branch");
    clear_flags(); issue_vld = 0; rst = 1; run_cycle("R11 reset mid");
    rst = 0; issue_vld = 1; cls_long = 1; run_cycle("R11 long after reset");

    for (int i = 0; i < 4000; i++) begin
      clear_flags();
      issue_vld   = ($urandom % 4) != 0;
      flush       = ($urandom % 16) == 0;
      fpu_standby = ($urandom % 2) == 0;
      case ($urandom % 10)
        0, 1: begin cls_dbranch = 1; cls_pcwrite = 1; end
        2: begin cls_trap = 1; cls_pcwrite = 1; end
        3: cls_pcwrite = 1;
        4: cls_long = 1;
        5: cls_bankrest = 1;
        6: cls_sdiv = 1;
        7: cls_udiv = 1;
        8: cls_fpu = 1;
        default: ;
      endcase
      cls_undef = ($urandom % 12) == 0;
      trap_vec  = VEC_W'($urandom);
      case ($urandom % 4)
        0: divisor = 0;
        1: divisor = MINUS1;
        default: divisor = $urandom;
      endcase
      dividend = (($urandom % 2) == 0) ? MOST_NEG : $urandom;
      run_cycle("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule